// File: doc/BRIEF.md
# Four-Bit Carry Lookahead Adder

This block adds two 4-bit unsigned operands and an incoming carry in pure combinational logic. A small cell per bit forms a propagate term (the XOR of the two operand bits) and a generate term (their AND). Each carry is then formed as a flat sum of products of those terms and the incoming carry. No carry passes from one stage to the next, so every carry has the same two-level depth.

Each sum bit is the XOR of its bit's propagate term and the carry into that bit. The block also drives a group generate and a group propagate output. A higher-level lookahead stage can combine these when several units are placed side by side. Bit 0 is the least significant bit, and the incoming carry enters at bit 0.

Top module: `cla_adder4`

## Requirements
- R1: `sum_o` equals the low four bits of `a_i + b_i + carry_i`, for every one of the 512 input combinations.
- R2: `carry_o` equals bit 4 of `a_i + b_i + carry_i`.
- R3: `grp_gen_o` is 1 exactly when `a_i + b_i` exceeds 15, that is, when the unit produces a carry without help from `carry_i`.
- R4: `grp_prop_o` is 1 exactly when `a_i ^ b_i` is 4'b1111, that is, when `a_i + b_i` equals 15.
- R5: While `grp_prop_o` is 1, `carry_o` equals `carry_i`, so an incoming carry passes through all four bits.
- R6: `carry_o` equals `grp_gen_o | (grp_prop_o & carry_i)` at all times, so two units can be cascaded through the group terms.
- R7: The block holds no state. Its outputs depend only on the present inputs and settle in the same cycle the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| carry_i | input | 1 | Incoming carry into bit 0 |
| sum_o | output | 4 | Sum bits |
| carry_o | output | 1 | Carry out of bit 3 |
| grp_gen_o | output | 1 | Group generate for cascading |
| grp_prop_o | output | 1 | Group propagate for cascading |

## Verification
Every result is due zero cycles after its stimulus, because no register lies between any input and any output. The bench applies each input set on a rising clock edge and samples the outputs on the following falling edge, half a period later. By then the combinational paths have settled. Because a new stimulus is never applied before the previous sample is taken, each check sees the outputs of exactly one input set.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int CLA_W = 4;

    typedef struct packed {
        logic [CLA_W-1:0] sum;
        logic             cout;
        logic             gg;
        logic             gp;
    } cla_res_t;
endpackage

// File: rtl/cla_pg_cell.sv
module cla_pg_cell (
    input  logic a,
    input  logic b,
    output logic p,
    output logic g
);
    always_comb begin
        p = a ^ b;
        g = a & b;
    end
endmodule

// File: rtl/cla_carry_net.sv
module cla_carry_net #(
    parameter int W = cla_pkg::CLA_W
) (
    input  logic [W-1:0] p,
    input  logic [W-1:0] g,
    input  logic         cin,
    output logic [W:0]   c,
    output logic         gg,
    output logic         gp
);
    assign c[0] = cin;

    // Carry into bit i+1: a flat OR of product terms.
    // For each j <= i the term is g[j] AND all propagates above j up to i.
    // The last term is cin AND all propagates from i down to 0.
    for (genvar i = 0; i < W; i++) begin : g_carry
        logic [i+1:0] term;
        for (genvar j = 0; j <= i; j++) begin : g_term
            if (j == i) begin : g_top
                assign term[j] = g[j];
            end else begin : g_mid
                assign term[j] = g[j] & (&p[i:j+1]);
            end
        end
        assign term[i+1] = cin & (&p[i:0]);
        assign c[i+1]    = |term;
    end

    // Group terms leave out the incoming carry.
    assign gg = |g_carry[W-1].term[W-1:0];
    assign gp = &p;
endmodule

// File: rtl/cla_sum_stage.sv
module cla_sum_stage #(
    parameter int W = cla_pkg::CLA_W
) (
    input  logic [W-1:0]     p,
    input  logic [W:0]       c,
    input  logic             gg,
    input  logic             gp,
    output cla_pkg::cla_res_t res
);
    cla_pkg::cla_res_t res_d;

    always_comb begin
        res_d      = '0;
        res_d.sum  = p ^ c[W-1:0];
        res_d.cout = c[W];
        res_d.gg   = gg;
        res_d.gp   = gp;
    end

    assign res = res_d;
endmodule

// File: rtl/cla_adder4.sv
module cla_adder4 (
    input  logic [3:0] a_i,
    input  logic [3:0] b_i,
    input  logic       carry_i,
    output logic [3:0] sum_o,
    output logic       carry_o,
    output logic       grp_gen_o,
    output logic       grp_prop_o
);
    localparam int W = cla_pkg::CLA_W;

    logic [W-1:0]      p_w;
    logic [W-1:0]      g_w;
    logic [W:0]        c_w;
    logic              gg_w;
    logic              gp_w;
    cla_pkg::cla_res_t res_w;

    for (genvar k = 0; k < W; k++) begin : g_bit
        cla_pg_cell u_pg (
            .a (a_i[k]),
            .b (b_i[k]),
            .p (p_w[k]),
            .g (g_w[k])
        );
    end

    cla_carry_net #(.W(W)) u_carry (
        .p   (p_w),
        .g   (g_w),
        .cin (carry_i),
        .c   (c_w),
        .gg  (gg_w),
        .gp  (gp_w)
    );

    cla_sum_stage #(.W(W)) u_sum (
        .p   (p_w),
        .c   (c_w),
        .gg  (gg_w),
        .gp  (gp_w),
        .res (res_w)
    );

    assign sum_o      = res_w.sum;
    assign carry_o    = res_w.cout;
    assign grp_gen_o  = res_w.gg;
    assign grp_prop_o = res_w.gp;

    // Checks against the outputs of separate submodules.
    always_comb begin
        AST_SUM_MATCH: assert ({res_w.cout, res_w.sum} == ({1'b0, a_i} + {1'b0, b_i} + {4'd0, carry_i})); // R1
        AST_CASCADE_EQ: assert (res_w.cout == (res_w.gg | (res_w.gp & carry_i))); // R6
        AST_PROP_PASS: assert (!res_w.gp || (res_w.cout == carry_i)); // R5
        AST_GEN_NOT_PROP: assert (!(res_w.gg && res_w.gp)); // R3
    end
endmodule

// File: tb/sim_cla_adder4.sv
module sim_cla_adder4;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [3:0] a_s = '0;
    logic [3:0] b_s = '0;
    logic       c_s = 1'b0;
    logic [3:0] sum_w;
    logic       cout_w;
    logic       gg_w;
    logic       gp_w;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cla_adder4 u0 (
        .a_i        (a_s),
        .b_i        (b_s),
        .carry_i    (c_s),
        .sum_o      (sum_w),
        .carry_o    (cout_w),
        .grp_gen_o  (gg_w),
        .grp_prop_o (gp_w)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
                     req, a_s, b_s, c_s, act, exp);
        end
    endtask

    // Drive on a rising edge, sample on the next falling edge.
    task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic ci);
        @(posedge clk);
        a_s = a;
        b_s = b;
        c_s = ci;
        @(negedge clk);
    endtask

    task automatic check_all();
        int tot;
        tot = int'(a_s) + int'(b_s) + int'(c_s);
        check("R1", int'(sum_w), tot % 16);
        check("R2", int'(cout_w), tot / 16);
        check("R3", int'(gg_w), ((int'(a_s) + int'(b_s)) > 15) ? 1 : 0);
        check("R4", int'(gp_w), ((a_s ^ b_s) == 4'hF) ? 1 : 0);
        check("R6", int'(cout_w), int'(gg_w | (gp_w & c_s)));
    endtask

    // R7: all-zero inputs give all-zero outputs without any clocked state.
    task automatic t_zero();
        apply(4'd0, 4'd0, 1'b0);
        check("R7", int'({sum_w, cout_w, gg_w, gp_w}), 0);
        check_all();
    endtask

    // R5: full propagate chain, carry passes through all four bits.
    task automatic t_prop_chain();
        apply(4'hF, 4'h0, 1'b1);
        check("R5", int'(cout_w), 1);
        check("R5", int'(sum_w), 0);
        apply(4'hA, 4'h5, 1'b0);
        check("R5", int'(cout_w), 0);
        check("R4", int'(gp_w), 1);
        apply(4'h9, 4'h6, 1'b1);
        check("R5", int'(cout_w), 1);
    endtask

    // R3: generate from the top bit and from the bottom bit through propagates.
    task automatic t_generate();
        apply(4'h8, 4'h8, 1'b0);
        check("R3", int'(gg_w), 1);
        check("R2", int'(cout_w), 1);
        check("R1", int'(sum_w), 0);
        apply(4'h1, 4'hF, 1'b0);
        check("R3", int'(gg_w), 1);
        check("R1", int'(sum_w), 0);
        apply(4'hF, 4'hF, 1'b1);
        check("R1", int'(sum_w), 15);
        check("R2", int'(cout_w), 1);
    endtask

    // R1 R2 R3 R4 R6: every operand and carry combination.
    task automatic t_exhaustive();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int ci = 0; ci < 2; ci++) begin
                    apply(4'(a), 4'(b), 1'(ci));
                    check_all();
                end
    endtask

    // R7: changing inputs between edges updates outputs within half a period.
    task automatic t_comb();
        apply(4'd3, 4'd4, 1'b0);
        #1;
        a_s = 4'd5;
        #1;
        check("R7", int'(sum_w), 9);
    endtask

    initial begin
        t_zero();
        t_prop_chain();
        t_generate();
        t_exhaustive();
        t_comb();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R7 actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule